// File: doc/BRIEF.md
# Dual-Wiper Potentiometer Register Bank

This block is the register store that sits behind a two-wire serial slave in a digitally controlled potentiometer. The bus engine decodes bit timing and hands the block byte-level events: an address byte, each received data byte, each request for a read byte, and the STOP condition. The block keeps four volatile wiper codes, sixteen storage bytes arranged as four rows of four (one per wiper in each row), and a three-bit status register. It drives the four wiper codes to the resistor decoders and raises a busy flag while a timed storage commit runs.

The status register chooses where bytes go. With its storage-select bit clear, bytes address the wiper registers directly. With it set, bytes address the storage row that the status row field names. Any contact with that row, whether a status write, a storage write or a storage read, also copies the row into the wiper registers. Storage bytes are held in a staging buffer during the transaction. They are committed at STOP only when the write-permit input is high, and the commit then holds the block busy for a configurable number of clock cycles. During that time every bus event is ignored, and the engine uses busy to withhold its acknowledge.

Top module: `pot_bank_mgr`

## Requirements
- R1: Synchronous reset loads each wiper register from row 0 of storage, clears the status register to 00h, points the address at slot 0 and clears busy. Storage keeps its contents across reset and starts at the parameter INIT_CODE.
- R2: The address byte low bits select the target. 0, 1, 2 and 3 are wiper slots 0 to 3, in the page order wiper 0A, 1B, 1A, 0B. Slot k drives wipers_o[8k+7:8k]. Value 7 selects the status register. Values 4 to 6 are unused: writes to them change nothing and reads return 00h.
- R3: The status register holds bit 0 as storage-select and bits 2:1 as the storage row. Bits above bit 2 are dropped on write and read back as zero.
- R4: A status write with bit 0 set copies all four bytes of the chosen row into the wiper registers. The new codes appear the cycle after the data byte.
- R5: With storage-select clear, a data byte writes only the addressed wiper register, takes effect the next cycle, and STOP does not raise busy.
- R6: After each accepted data byte on a slot, the slot pointer advances by one and wraps from 3 to 0. A fifth byte therefore overwrites the first slot of the page.
- R7: With storage-select set, a data byte sets the addressed wiper to that byte. Each other wiper takes the byte already staged for it in this transaction, or else its stored value from the selected row.
- R8: A read returns the byte at the current pointer one cycle after the request, flagged by rd_valid_o, and advances the pointer as in R6. A storage read also copies the selected row into the wiper registers. A read of the status address returns the status and does not move.
- R9: STOP after at least one staged storage byte, with nv_wr_en_i high, commits the staged bytes into the selected row. busy_o then stays high for exactly NV_CYCLES cycles, starting the cycle after STOP.
- R10: STOP with nv_wr_en_i low discards the staged bytes and leaves busy_o low. Storage is unchanged, but wiper codes already written stay.
- R11: While busy_o is high, address bytes, data bytes, read requests and STOP are ignored. Wiper codes hold and no read data is returned.
- R12: An address byte with any of bits 7:3 set leaves the pointer unchanged, and every data byte until the next address byte is ignored.
- R13: rd_data_o holds its value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_wr_en_i | input | 1 | Write permit for storage commits, high allows |
| addr_valid_i | input | 1 | Pulse: address byte received, starts a transaction |
| addr_byte_i | input | 8 | Address byte |
| wr_valid_i | input | 1 | Pulse: data byte received |
| wr_data_i | input | CODE_W | Data byte |
| rd_req_i | input | 1 | Pulse: engine needs the next read byte |
| stop_i | input | 1 | Pulse: STOP condition seen |
| rd_valid_o | output | 1 | Read byte valid (one cycle) |
| rd_data_o | output | CODE_W | Read byte |
| wipers_o | output | 4*CODE_W | Wiper codes, slot k in bits [CODE_W*k +: CODE_W] |
| busy_o | output | 1 | Storage commit in progress |

## Verification
The bound checker watches, on every cycle, that wiper codes and read data never move while busy or without a bus event. It also checks that busy only rises after a permitted STOP and that each busy period lasts exactly NV_CYCLES cycles. Only the bench scenarios can show which values land where: the slot order and wrap, the staged-versus-stored mix during a storage page write, the row copies triggered by status writes and storage reads, data discarded under write-protect, and storage surviving reset.

// File: rtl/pot_bank_pkg.sv
package pot_bank_pkg;

    localparam int SLOTS = 4;
    localparam int ROWS  = 4;
    localparam logic [2:0] STATUS_ADDR = 3'd7;

    typedef logic [$clog2(SLOTS)-1:0] slot_t;

    typedef enum logic [1:0] {
        TGT_SLOT   = 2'd0,
        TGT_STATUS = 2'd1,
        TGT_NONE   = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [1:0] row;
        logic       nv;
    } stat_t;

    function automatic tgt_e decode_target(input logic [2:0] low);
        if (low < 3'(SLOTS))          return TGT_SLOT;
        else if (low == STATUS_ADDR)  return TGT_STATUS;
        else                          return TGT_NONE;
    endfunction

    function automatic slot_t slot_next(input slot_t s);
        return slot_t'(s + 1'b1);
    endfunction

endpackage

// File: rtl/pot_bank_addr_ctl.sv
module pot_bank_addr_ctl
    import pot_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] addr_byte_i,
    input  logic       step_i,
    output slot_t      slot_o,
    output tgt_e       tgt_o,
    output logic       block_o
);
    slot_t slot_q;
    tgt_e  tgt_q;
    logic  block_q;
    logic  upper_set;

    assign upper_set = |addr_byte_i[7:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            tgt_q   <= TGT_SLOT;
            block_q <= 1'b0;
        end else if (load_i) begin
            block_q <= upper_set;
            if (!upper_set) begin
                tgt_q <= decode_target(addr_byte_i[2:0]);
                if (decode_target(addr_byte_i[2:0]) == TGT_SLOT)
                    slot_q <= slot_t'(addr_byte_i[1:0]);
            end
        end else if (step_i && tgt_q == TGT_SLOT) begin
            slot_q <= slot_next(slot_q);
        end
    end

    assign slot_o  = slot_q;
    assign tgt_o   = tgt_q;
    assign block_o = block_q;
endmodule

// File: rtl/pot_bank_nv_timer.sv
module pot_bank_nv_timer #(
    parameter int NV_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CW'(NV_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pot_bank_stage.sv
module pot_bank_stage
    import pot_bank_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear_i,
    input  logic                          load_i,
    input  slot_t                         slot_i,
    input  logic [CODE_W-1:0]             data_i,
    output logic [SLOTS-1:0]              mask_o,
    output logic [SLOTS-1:0][CODE_W-1:0]  bytes_o
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic              hit;
        logic              vld_q;
        logic [CODE_W-1:0] byte_q;

        assign hit = load_i && (slot_i == slot_t'(k));

        always_ff @(posedge clk) begin
            if (rst || clear_i)
                vld_q <= 1'b0;
            else if (hit)
                vld_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit)
                byte_q <= data_i;
        end

        assign mask_o[k]  = vld_q;
        assign bytes_o[k] = byte_q;
    end
endmodule

// File: rtl/pot_bank_mgr.sv
module pot_bank_mgr
    import pot_bank_pkg::*;
#(
    parameter int                CODE_W    = 8,
    parameter int                NV_CYCLES = 1000000,
    parameter logic [CODE_W-1:0] INIT_CODE = CODE_W'(8'h80)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    nv_wr_en_i,
    input  logic                    addr_valid_i,
    input  logic [7:0]              addr_byte_i,
    input  logic                    wr_valid_i,
    input  logic [CODE_W-1:0]       wr_data_i,
    input  logic                    rd_req_i,
    input  logic                    stop_i,
    output logic                    rd_valid_o,
    output logic [CODE_W-1:0]       rd_data_o,
    output logic [SLOTS*CODE_W-1:0] wipers_o,
    output logic                    busy_o
);
    localparam int PAD_W = CODE_W - $bits(stat_t);

    slot_t                        slot;
    tgt_e                         tgt;
    logic                         blocked;
    logic                         busy;
    logic [SLOTS-1:0]             st_mask;
    logic [SLOTS-1:0][CODE_W-1:0] st_bytes;

    stat_t                        stat_q;
    logic [SLOTS-1:0][CODE_W-1:0] wip_q;
    logic [SLOTS-1:0][CODE_W-1:0] store_q [ROWS] = '{default: {SLOTS{INIT_CODE}}};
    logic                         rd_valid_q;
    logic [CODE_W-1:0]            rd_data_q;

    logic addr_ev, wr_ev, rd_ev, stop_ev;
    logic wr_slot, wr_stat, dr_wr, wcr_wr, rd_slot, commit;

    assign addr_ev = addr_valid_i && !busy;
    assign wr_ev   = wr_valid_i   && !busy && !blocked;
    assign rd_ev   = rd_req_i     && !busy;
    assign stop_ev = stop_i       && !busy;

    assign wr_slot = wr_ev && (tgt == TGT_SLOT);
    assign wr_stat = wr_ev && (tgt == TGT_STATUS);
    assign dr_wr   = wr_slot &&  stat_q.nv;
    assign wcr_wr  = wr_slot && !stat_q.nv;
    assign rd_slot = rd_ev && (tgt == TGT_SLOT);
    assign commit  = stop_ev && (|st_mask) && nv_wr_en_i;

    pot_bank_addr_ctl u_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (addr_ev),
        .addr_byte_i (addr_byte_i),
        .step_i      (wr_slot || rd_slot),
        .slot_o      (slot),
        .tgt_o       (tgt),
        .block_o     (blocked)
    );

    pot_bank_stage #(.CODE_W(CODE_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .clear_i (addr_ev || stop_ev),
        .load_i  (dr_wr),
        .slot_i  (slot),
        .data_i  (wr_data_i),
        .mask_o  (st_mask),
        .bytes_o (st_bytes)
    );

    pot_bank_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (busy)
    );

    // Storage: not reset, committed only at a permitted STOP.
    always_ff @(posedge clk) begin
        if (!rst && commit) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (st_mask[k])
                    store_q[stat_q.row][k] <= st_bytes[k];
            end
        end
    end

    // Status register and wiper registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            for (int k = 0; k < SLOTS; k++)
                wip_q[k] <= store_q[0][k];
        end else begin
            if (wr_stat) begin
                stat_q <= stat_t'(wr_data_i[2:0]);
                if (wr_data_i[0]) begin
                    for (int k = 0; k < SLOTS; k++)
                        wip_q[k] <= store_q[wr_data_i[2:1]][k];
                end
            end
            if (wcr_wr)
                wip_q[slot] <= wr_data_i;
            if (dr_wr) begin
                for (int k = 0; k < SLOTS; k++) begin
                    if (slot == slot_t'(k))
                        wip_q[k] <= wr_data_i;
                    else if (st_mask[k])
                        wip_q[k] <= st_bytes[k];
                    else
                        wip_q[k] <= store_q[stat_q.row][k];
                end
            end
            if (rd_slot && stat_q.nv) begin
                for (int k = 0; k < SLOTS; k++)
                    wip_q[k] <= store_q[stat_q.row][k];
            end
        end
    end

    // Read path.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_ev;
            if (rd_ev) begin
                unique case (tgt)
                    TGT_SLOT:   rd_data_q <= stat_q.nv ? store_q[stat_q.row][slot] : wip_q[slot];
                    TGT_STATUS: rd_data_q <= {{PAD_W{1'b0}}, stat_q};
                    default:    rd_data_q <= '0;
                endcase
            end
        end
    end

    assign wipers_o   = wip_q;
    assign busy_o     = busy;
    assign rd_valid_o = rd_valid_q;
    assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/pot_bank_mgr_chk.sv
module pot_bank_mgr_chk #(
    parameter int CODE_W    = 8,
    parameter int NV_CYCLES = 1000000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  nv_wr_en_i,
    input logic                  wr_valid_i,
    input logic                  rd_req_i,
    input logic                  stop_i,
    input logic                  rd_valid_o,
    input logic [CODE_W-1:0]     rd_data_o,
    input logic [4*CODE_W-1:0]   wipers_o,
    input logic                  busy_o
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (busy_o)
            run_q <= run_q + 1;
        else
            run_q <= '0;
    end

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(wipers_o));

    // R11
    busy_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !rd_valid_o);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(stop_i) && $past(nv_wr_en_i)));

    // R9
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= 32'(NV_CYCLES));

    // R9
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == 32'(NV_CYCLES)));

    // R5
    wiper_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid_i && !rd_req_i) |=> $stable(wipers_o));

    // R13
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> ($stable(rd_data_o) && !rd_valid_o));
endmodule

bind pot_bank_mgr pot_bank_mgr_chk #(
    .CODE_W    (CODE_W),
    .NV_CYCLES (NV_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nv_wr_en_i (nv_wr_en_i),
    .wr_valid_i (wr_valid_i),
    .rd_req_i   (rd_req_i),
    .stop_i     (stop_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .wipers_o   (wipers_o),
    .busy_o     (busy_o)
);

// File: tb/test_pot_bank_mgr.sv
module test_pot_bank_mgr;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nv_wr_en_i = 1'b1;
    logic        addr_valid_i = 1'b0;
    logic [7:0]  addr_byte_i = '0;
    logic        wr_valid_i = 1'b0;
    logic [7:0]  wr_data_i = '0;
    logic        rd_req_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        rd_valid_o;
    logic [7:0]  rd_data_o;
    logic [31:0] wipers_o;
    logic        busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    pot_bank_mgr #(.CODE_W(8), .NV_CYCLES(NV), .INIT_CODE(8'h80)) i_pot_bank_mgr (
        .clk(clk), .rst(rst), .nv_wr_en_i(nv_wr_en_i),
        .addr_valid_i(addr_valid_i), .addr_byte_i(addr_byte_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .rd_req_i(rd_req_i), .stop_i(stop_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .wipers_o(wipers_o), .busy_o(busy_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_wip(input string tag, input logic [7:0] s0, s1, s2, s3);
        check(tag, wipers_o, {s3, s2, s1, s0});
    endtask

    task automatic send_addr(input logic [7:0] a);
        @(negedge clk); addr_byte_i = a; addr_valid_i = 1'b1;
        @(negedge clk); addr_valid_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); wr_data_i = d; wr_valid_i = 1'b1;
        @(negedge clk); wr_valid_i = 1'b0;
    endtask

    task automatic do_stop(input logic wp);
        @(negedge clk); nv_wr_en_i = wp; stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] e);
        exp_q.push_back(e);
        @(negedge clk); rd_req_i = 1'b1;
        @(negedge clk); rd_req_i = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor: each returned read byte is compared with the queue head.
    always @(negedge clk) begin
        if (!rst && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read data", {24'h0, rd_data_o}, 32'hFFFF_FFFF);
            end else begin
                check("R8 read data", {24'h0, rd_data_o}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_wip("R1 reset wipers", 8'h80, 8'h80, 8'h80, 8'h80);
        check("R1 reset busy", {31'h0, busy_o}, 0);
        rd_exp(8'h80);

        // R5 / R6: direct wiper writes with wrap
        send_addr(8'h00); send_byte(8'h11);
        chk_wip("R5 single wiper write", 8'h11, 8'h80, 8'h80, 8'h80);
        send_addr(8'h02); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        chk_wip("R6 page wrap 3 to 0", 8'h44, 8'h80, 8'h22, 8'h33);
        do_stop(1'b1);
        check("R5 no busy after wiper write", {31'h0, busy_o}, 0);

        // R8 / R2: reads from slot 1 with wrap
        send_addr(8'h01); do_stop(1'b1);
        rd_exp(8'h80); rd_exp(8'h22); rd_exp(8'h33); rd_exp(8'h44);

        // R4 / R3: status write copies row 1, reserved bits read zero
        send_addr(8'h07); send_byte(8'h03);
        chk_wip("R4 status copies row", 8'h80, 8'h80, 8'h80, 8'h80);
        rd_exp(8'h03);
        send_byte(8'hF3);
        rd_exp(8'h03);   // R3 reserved bits dropped
        do_stop(1'b1);

        // R7 / R9 / R11: storage page write, commit, busy
        send_addr(8'h03); send_byte(8'hA1);
        chk_wip("R7 storage write mixes row", 8'h80, 8'h80, 8'h80, 8'hA1);
        send_byte(8'hA2);
        chk_wip("R7 staged byte kept", 8'hA2, 8'h80, 8'h80, 8'hA1);
        do_stop(1'b1);
        check("R9 busy after STOP", {31'h0, busy_o}, 1);
        send_addr(8'h00); send_byte(8'h55);
        @(negedge clk); rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
        chk_wip("R11 events ignored when busy", 8'hA2, 8'h80, 8'h80, 8'hA1);
        check("R11 still busy", {31'h0, busy_o}, 1);
        while (busy_o) @(negedge clk);

        // R4 / R9: committed row visible through status copies
        send_addr(8'h07); send_byte(8'h01);
        chk_wip("R4 row 0 copy", 8'h80, 8'h80, 8'h80, 8'h80);
        send_byte(8'h03);
        chk_wip("R9 committed row 1", 8'hA2, 8'h80, 8'h80, 8'hA1);
        do_stop(1'b1);

        // R10: protected commit discarded
        send_addr(8'h07); send_byte(8'h05); do_stop(1'b1);
        send_addr(8'h00); send_byte(8'h77);
        chk_wip("R7 row 2 write", 8'h77, 8'h80, 8'h80, 8'h80);
        do_stop(1'b0);
        check("R10 no busy when protected", {31'h0, busy_o}, 0);
        send_addr(8'h07); send_byte(8'h05);
        chk_wip("R10 storage unchanged", 8'h80, 8'h80, 8'h80, 8'h80);
        do_stop(1'b1);

        // R8: storage read copies row into wipers
        send_addr(8'h07); send_byte(8'h03); do_stop(1'b1);
        send_addr(8'h01); send_byte(8'h99);
        chk_wip("R7 other wipers from row", 8'hA2, 8'h99, 8'h80, 8'hA1);
        do_stop(1'b0);
        send_addr(8'h01); do_stop(1'b1);
        rd_exp(8'h80);
        chk_wip("R8 read copies row", 8'hA2, 8'h80, 8'h80, 8'hA1);

        // R2 / R12: unused address and bad upper bits
        send_addr(8'h07); send_byte(8'h00); do_stop(1'b1);
        chk_wip("R3 select clear no copy", 8'hA2, 8'h80, 8'h80, 8'hA1);
        send_addr(8'h05); send_byte(8'h66);
        chk_wip("R2 unused address write ignored", 8'hA2, 8'h80, 8'h80, 8'hA1);
        do_stop(1'b1);
        rd_exp(8'h00);   // R2 unused reads zero
        send_addr(8'h02); do_stop(1'b1);
        send_addr(8'h40); send_byte(8'h12);
        chk_wip("R12 bad address data ignored", 8'hA2, 8'h80, 8'h80, 8'hA1);
        do_stop(1'b1);
        rd_exp(8'h80);   // R12 pointer still slot 2

        // R9: busy length, then R1 storage survives reset
        send_addr(8'h07); send_byte(8'h01); do_stop(1'b1);
        send_addr(8'h00); send_byte(8'hC4);
        do_stop(1'b1);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        check("R9 busy length", n, NV);
        send_addr(8'h07); send_byte(8'h00); do_stop(1'b1);
        send_addr(8'h00); send_byte(8'h00); do_stop(1'b1);
        chk_wip("R5 wiper cleared", 8'h00, 8'h80, 8'h80, 8'h80);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk_wip("R1 recall row 0 after reset", 8'hC4, 8'h80, 8'h80, 8'h80);
        check("R1 busy clear", {31'h0, busy_o}, 0);
        rd_exp(8'hC4);
        repeat (3) @(negedge clk);
        check("R13 read data held", {24'h0, rd_data_o}, 32'hC4);

        check("R8 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule